// File: doc/BRIEF.md
# Level-Prioritised Interrupt Pending Unit

This block keeps the pending state and the enable mask for a set of interrupt lines. Each line has a fixed priority level and a fixed kind. Parameters set both. A line is one of four kinds: software-raised, edge-sensitive, level-sensitive or non-maskable. Every cycle the block finds the highest level that has a line both pending and eligible. It then decides whether that level may interrupt the core, given the current interrupt level that the block holds. It drives a take request and the candidate level to an exception entry controller.

Software may raise or drop pending bits with masked writes. A set write affects only software lines. A clear write affects only software and edge lines. When the non-maskable level is taken, all non-maskable pending bits are dropped. A wait-for-interrupt request loads a new current level. If nothing can be taken at that level, the block reports the core as halted until an acceptable interrupt appears. Vector generation and status-word updates belong to the controller.

Top module: `irqp_unit`

## Requirements
- R1: While reset is asserted, pend_o, cur_level_o, take_o, take_level_o and halted_o are all zero. The enable mask also resets to zero.
- R2: A set write (sw_set_valid) ORs sw_data into the pending bits of software-kind lines only. Pending bits of edge, level and non-maskable lines do not change.
- R3: A clear write (sw_clr_valid) drops the pending bits selected by sw_data, but only on software and edge lines. Level and non-maskable lines do not change.
- R4: An edge or non-maskable line sets its pending bit one clock after a 0-to-1 change of its irq_in bit. A level line's pending bit equals its irq_in bit of the previous clock.
- R5: take_level_o is the highest level that has a line both pending and eligible, or 0 if there is none. A maskable line is eligible when its enable bit is 1. A non-maskable line is always eligible.
- R6: take_o is 1 for a maskable candidate level only when that level is strictly greater than cur_level_o and no greater than NUM_LEVELS. A candidate above NUM_LEVELS is refused, and it also hides any lower pending levels.
- R7: A candidate equal to NMI_LEVEL gives take_o = 1, whatever cur_level_o and the enable mask hold.
- R8: In a cycle with take_o = 1 and take_level_o = NMI_LEVEL, every non-maskable pending bit is cleared at the next clock. The exception is a bit whose line rises in that same cycle.
- R9: On a single line, a set in one cycle beats a clear in the same cycle. For an edge line, a rising edge beats a clear write. For a software line, a set write together with a clear write leaves the bit at 1.
- R10: wfi_req loads wfi_level into cur_level_o at the next clock. halted_o becomes 1 at that clock if the candidate level is not acceptable against wfi_level, and 0 otherwise. Once set, halted_o clears at the clock after take_o becomes 1.
- R11: enable_wr loads enable_data into the enable mask. cur_level_wr loads cur_level_data into cur_level_o. Both take effect at the next clock, and wfi_req wins over cur_level_wr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | N_LINES | Raw interrupt line inputs |
| sw_set_valid | input | 1 | Software set write strobe |
| sw_clr_valid | input | 1 | Software clear write strobe |
| sw_data | input | N_LINES | Line mask for set and clear writes |
| enable_wr | input | 1 | Enable mask write strobe |
| enable_data | input | N_LINES | New enable mask |
| cur_level_wr | input | 1 | Current level write strobe |
| cur_level_data | input | LVL_W | New current level |
| wfi_req | input | 1 | Wait-for-interrupt request |
| wfi_level | input | LVL_W | Current level loaded by wait-for-interrupt |
| pend_o | output | N_LINES | Pending register |
| cur_level_o | output | LVL_W | Current interrupt level |
| take_o | output | 1 | Candidate level may be taken |
| take_level_o | output | LVL_W | Candidate (highest eligible pending) level |
| halted_o | output | 1 | Core halted waiting for an interrupt |

## Verification
The hardest cases to reach from the ports are the same-cycle collisions. In one, a rising edge lands together with a clear write on the same edge line. In another, a set and a clear hit the same software line at once. The stimulus first drops the input and lets the edge detector settle low. It then raises the input in the very cycle the clear strobe is asserted. The halted exit is also awkward to reach. The bench waits at a raised level, posts a lower-level interrupt that must not wake the core, and then posts a higher one. It checks that take comes one clock before halted falls.

// File: rtl/irqp_pkg.sv
package irqp_pkg;

  localparam logic [1:0] KIND_SW    = 2'd0;
  localparam logic [1:0] KIND_EDGE  = 2'd1;
  localparam logic [1:0] KIND_LEVEL = 2'd2;
  localparam logic [1:0] KIND_NMI   = 2'd3;

  // Acceptance rule: non-maskable level always, otherwise strictly above the
  // current level and inside the configured range. Level 0 means "none".
  function automatic logic level_ok(input logic [7:0] plev,
                                    input logic [7:0] cur,
                                    input logic [7:0] top_lvl,
                                    input logic [7:0] nmi_lvl);
    return (plev != 8'd0) &&
           ((plev == nmi_lvl) || ((plev > cur) && (plev <= top_lvl)));
  endfunction

endpackage

// File: rtl/irqp_line_bank.sv
module irqp_line_bank #(
  parameter int N_LINES = 8,
  parameter logic [2*N_LINES-1:0] LINE_KIND = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] irq_in,
  input  logic               sw_set_valid,
  input  logic               sw_clr_valid,
  input  logic [N_LINES-1:0] sw_data,
  input  logic               nmi_clear,
  output logic [N_LINES-1:0] pend
);
  import irqp_pkg::*;

  logic [N_LINES-1:0] irq_q;
  logic [N_LINES-1:0] rise;
  logic [N_LINES-1:0] set_hit;
  logic [N_LINES-1:0] clr_hit;
  logic [N_LINES-1:0] pend_d;

  assign rise    = irq_in & ~irq_q;
  assign set_hit = sw_set_valid ? sw_data : '0;
  assign clr_hit = sw_clr_valid ? sw_data : '0;

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    if (LINE_KIND[2*i +: 2] == KIND_SW) begin : g_sw
      assign pend_d[i] = (pend[i] & ~clr_hit[i]) | set_hit[i];
      assert_sw_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        set_hit[i] |=> pend[i]);
      assert_sw_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_hit[i] && !set_hit[i]) |=> !pend[i]);
    end else if (LINE_KIND[2*i +: 2] == KIND_EDGE) begin : g_edge
      assign pend_d[i] = (pend[i] & ~clr_hit[i]) | rise[i];
      assert_rise_beats_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rise[i] |=> pend[i]);
      assert_edge_ignores_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend[i] && !rise[i] && set_hit[i]) |=> !pend[i]);
    end else if (LINE_KIND[2*i +: 2] == KIND_LEVEL) begin : g_level
      assign pend_d[i] = irq_in[i];
      assert_level_mirror_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (pend[i] == $past(irq_in[i])));
    end else begin : g_nmi
      assign pend_d[i] = (pend[i] & ~nmi_clear) | rise[i];
      assert_nmi_autoclear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_clear && !rise[i]) |=> !pend[i]);
      assert_nmi_ignores_sw_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pend[i] && !nmi_clear && clr_hit[i]) |=> pend[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q <= '0;
      pend  <= '0;
    end else begin
      irq_q <= irq_in;
      pend  <= pend_d;
    end
  end

endmodule

// File: rtl/irqp_level_pick.sv
module irqp_level_pick #(
  parameter int N_LINES = 8,
  parameter int LVL_W   = 3,
  parameter logic [N_LINES*LVL_W-1:0] LINE_LEVEL = '0,
  parameter logic [2*N_LINES-1:0]     LINE_KIND  = '0
) (
  input  logic [N_LINES-1:0] pend,
  input  logic [N_LINES-1:0] enable,
  output logic [LVL_W-1:0]   pick
);
  import irqp_pkg::*;

  localparam int N_LVL = 1 << LVL_W;

  logic [N_LINES-1:0] elig;
  logic [N_LVL-1:0]   hit;

  for (genvar i = 0; i < N_LINES; i++) begin : g_elig
    if (LINE_KIND[2*i +: 2] == KIND_NMI) begin : g_nmi
      assign elig[i] = pend[i];
    end else begin : g_mask
      assign elig[i] = pend[i] & enable[i];
    end
  end

  // One OR-reduction per level over the lines statically assigned to it.
  for (genvar lv = 0; lv < N_LVL; lv++) begin : g_lvl
    logic [N_LINES-1:0] members;
    for (genvar i = 0; i < N_LINES; i++) begin : g_mem
      assign members[i] = (LINE_LEVEL[i*LVL_W +: LVL_W] == LVL_W'(lv));
    end
    if (lv == 0) begin : g_zero
      assign hit[lv] = 1'b0;
    end else begin : g_any
      assign hit[lv] = |(members & elig);
    end
  end

  always_comb begin
    pick = '0;
    for (int lv = 1; lv < N_LVL; lv++) begin
      if (hit[lv]) pick = LVL_W'(lv);
    end
  end

endmodule

// File: rtl/irqp_unit.sv
module irqp_unit #(
  parameter int N_LINES    = 8,
  parameter int LVL_W      = 3,
  parameter int NUM_LEVELS = 5,
  parameter int NMI_LEVEL  = 7,
  // line 7..0 levels: 6,7,5,3,4,2,3,1
  parameter logic [N_LINES*LVL_W-1:0] LINE_LEVEL =
    {3'd6, 3'd7, 3'd5, 3'd3, 3'd4, 3'd2, 3'd3, 3'd1},
  // line 7..0 kinds: sw, nmi, level, level, edge, edge, sw, sw
  parameter logic [2*N_LINES-1:0] LINE_KIND =
    {2'd0, 2'd3, 2'd2, 2'd2, 2'd1, 2'd1, 2'd0, 2'd0}
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] irq_in,
  input  logic               sw_set_valid,
  input  logic               sw_clr_valid,
  input  logic [N_LINES-1:0] sw_data,
  input  logic               enable_wr,
  input  logic [N_LINES-1:0] enable_data,
  input  logic               cur_level_wr,
  input  logic [LVL_W-1:0]   cur_level_data,
  input  logic               wfi_req,
  input  logic [LVL_W-1:0]   wfi_level,
  output logic [N_LINES-1:0] pend_o,
  output logic [LVL_W-1:0]   cur_level_o,
  output logic               take_o,
  output logic [LVL_W-1:0]   take_level_o,
  output logic               halted_o
);
  import irqp_pkg::*;

  localparam logic [7:0] TOP_LVL = 8'(NUM_LEVELS);
  localparam logic [7:0] NMI_LVL = 8'(NMI_LEVEL);

  logic [N_LINES-1:0] enable_q;
  logic [LVL_W-1:0]   cur_q;
  logic               halted_q;
  logic [N_LINES-1:0] pend;
  logic [LVL_W-1:0]   pick;
  logic               accept_now;
  logic               accept_wfi;
  logic               nmi_clear;
  logic [N_LINES-1:0] nmi_lines;

  for (genvar i = 0; i < N_LINES; i++) begin : g_nmask
    assign nmi_lines[i] = (LINE_KIND[2*i +: 2] == KIND_NMI);
  end

  irqp_line_bank #(.N_LINES(N_LINES), .LINE_KIND(LINE_KIND)) u_bank (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .sw_set_valid(sw_set_valid), .sw_clr_valid(sw_clr_valid), .sw_data(sw_data),
    .nmi_clear(nmi_clear), .pend(pend)
  );

  irqp_level_pick #(.N_LINES(N_LINES), .LVL_W(LVL_W),
                    .LINE_LEVEL(LINE_LEVEL), .LINE_KIND(LINE_KIND)) u_pick (
    .pend(pend), .enable(enable_q), .pick(pick)
  );

  assign accept_now = level_ok(8'(pick), 8'(cur_q), TOP_LVL, NMI_LVL);
  assign accept_wfi = level_ok(8'(pick), 8'(wfi_level), TOP_LVL, NMI_LVL);
  assign nmi_clear  = accept_now && (8'(pick) == NMI_LVL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable_q <= '0;
      cur_q    <= '0;
      halted_q <= 1'b0;
    end else begin
      if (enable_wr) enable_q <= enable_data;
      if (wfi_req)           cur_q <= wfi_level;
      else if (cur_level_wr) cur_q <= cur_level_data;
      if (wfi_req) halted_q <= !accept_wfi;
      else         halted_q <= halted_q && !accept_now;
    end
  end

  assign pend_o       = pend;
  assign cur_level_o  = cur_q;
  assign take_o       = accept_now;
  assign take_level_o = pick;
  assign halted_o     = halted_q;

  assert_take_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> ((8'(take_level_o) == NMI_LVL) ||
                ((take_level_o > cur_level_o) && (8'(take_level_o) <= TOP_LVL))));
  assert_nmi_always_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pend & nmi_lines)) |-> (take_o && (8'(take_level_o) == NMI_LVL)));
  assert_halt_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted_o) |-> $past(wfi_req));
  assert_wfi_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wfi_req |=> (cur_level_o == $past(wfi_level)));
  assert_cur_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_level_wr && !wfi_req) |=> (cur_level_o == $past(cur_level_data)));

endmodule

// File: tb/irqp_unit_bench.sv
module irqp_unit_bench;

  localparam int N = 8;
  localparam int W = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] irq_in = '0;
  logic         sw_set_valid = 1'b0;
  logic         sw_clr_valid = 1'b0;
  logic [N-1:0] sw_data = '0;
  logic         enable_wr = 1'b0;
  logic [N-1:0] enable_data = '0;
  logic         cur_level_wr = 1'b0;
  logic [W-1:0] cur_level_data = '0;
  logic         wfi_req = 1'b0;
  logic [W-1:0] wfi_level = '0;
  logic [N-1:0] pend_o;
  logic [W-1:0] cur_level_o;
  logic         take_o;
  logic [W-1:0] take_level_o;
  logic         halted_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  irqp_unit u_irqp_unit (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .sw_set_valid(sw_set_valid), .sw_clr_valid(sw_clr_valid), .sw_data(sw_data),
    .enable_wr(enable_wr), .enable_data(enable_data),
    .cur_level_wr(cur_level_wr), .cur_level_data(cur_level_data),
    .wfi_req(wfi_req), .wfi_level(wfi_level),
    .pend_o(pend_o), .cur_level_o(cur_level_o), .take_o(take_o),
    .take_level_o(take_level_o), .halted_o(halted_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic sw_set(input logic [N-1:0] m);
    sw_set_valid = 1'b1; sw_data = m; tick(); sw_set_valid = 1'b0; sw_data = '0;
  endtask

  task automatic sw_clr(input logic [N-1:0] m);
    sw_clr_valid = 1'b1; sw_data = m; tick(); sw_clr_valid = 1'b0; sw_data = '0;
  endtask

  task automatic set_cur(input logic [W-1:0] v);
    cur_level_wr = 1'b1; cur_level_data = v; tick(); cur_level_wr = 1'b0;
  endtask

  task automatic set_en(input logic [N-1:0] m);
    enable_wr = 1'b1; enable_data = m; tick(); enable_wr = 1'b0;
  endtask

  task automatic do_wfi(input logic [W-1:0] v);
    wfi_req = 1'b1; wfi_level = v; tick(); wfi_req = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "pend", 32'(pend_o), 0);
    chk("R1", "cur_level", 32'(cur_level_o), 0);
    chk("R1", "take", 32'(take_o), 0);
    chk("R1", "take_level", 32'(take_level_o), 0);
    chk("R1", "halted", 32'(halted_o), 0);
  endtask

  task automatic t_sw_masks();
    sw_set(8'hFF);
    chk("R2", "set reaches only software lines 0,1,7", 32'(pend_o), 32'h83);
    sw_clr(8'hFF);
    chk("R3", "clear of software lines", 32'(pend_o), 0);
    irq_in = 8'h1C; tick();
    chk("R4", "edges 2,3 latched, level 4 mirrored", 32'(pend_o), 32'h1C);
    sw_clr(8'hFF);
    chk("R3", "clear drops edge lines, keeps level line", 32'(pend_o), 32'h10);
    irq_in = 8'h00; tick();
    chk("R4", "level line follows input low, edges stay clear", 32'(pend_o), 0);
    sw_set(8'h7C);
    chk("R2", "set ignored on edge, level and nmi lines", 32'(pend_o), 0);
  endtask

  task automatic t_collision();
    irq_in = 8'h04; sw_clr_valid = 1'b1; sw_data = 8'h04; tick();
    sw_clr_valid = 1'b0; sw_data = '0;
    chk("R9", "edge rise beats same-cycle clear", 32'(pend_o), 32'h04);
    sw_set_valid = 1'b1; sw_clr_valid = 1'b1; sw_data = 8'h01; tick();
    sw_set_valid = 1'b0; sw_clr_valid = 1'b0; sw_data = '0;
    chk("R9", "software set beats same-cycle clear", 32'(pend_o), 32'h05);
    irq_in = 8'h00; sw_clr(8'h05);
    chk("R3", "cleanup clear", 32'(pend_o), 0);
  endtask

  task automatic t_priority();
    sw_set(8'h02);
    chk("R5", "disabled line yields no candidate", 32'(take_level_o), 0);
    chk("R5", "disabled line no take", 32'(take_o), 0);
    set_en(8'hFF);
    chk("R11", "enable write makes level 3 eligible", 32'(take_level_o), 3);
    chk("R11", "enabled level 3 taken at level 0", 32'(take_o), 1);
    sw_set(8'h01);
    chk("R5", "level 3 over level 1", 32'(take_level_o), 3);
    irq_in = 8'h20; tick();
    chk("R5", "level line 5 highest", 32'(take_level_o), 5);
    irq_in = 8'h00; tick();
    chk("R5", "back to level 3", 32'(take_level_o), 3);
    sw_clr(8'h02);
    chk("R5", "only level 1 left", 32'(take_level_o), 1);
  endtask

  task automatic t_accept();
    set_cur(3'd1);
    chk("R11", "current level loaded", 32'(cur_level_o), 1);
    chk("R6", "level equal to current refused", 32'(take_o), 0);
    chk("R6", "candidate still reported", 32'(take_level_o), 1);
    sw_set(8'h02);
    chk("R6", "level 3 above current 1 taken", 32'(take_o), 1);
    set_cur(3'd3);
    chk("R6", "level 3 at current 3 refused", 32'(take_o), 0);
    set_cur(3'd2);
    chk("R6", "level 3 at current 2 taken", 32'(take_o), 1);
    set_cur(3'd0);
    sw_set(8'h80);
    chk("R6", "level 6 is candidate", 32'(take_level_o), 6);
    chk("R6", "level above range refused and hides lower", 32'(take_o), 0);
    sw_clr(8'h83);
    chk("R5", "empty after clear", 32'(take_level_o), 0);
  endtask

  task automatic t_nmi();
    set_en(8'h00);
    set_cur(3'd7);
    irq_in = 8'h40; tick();
    chk("R7", "nmi pending bit", 32'(pend_o), 32'h40);
    chk("R7", "nmi taken at level 7 with enables off", 32'(take_o), 1);
    chk("R7", "nmi level", 32'(take_level_o), 7);
    tick();
    chk("R8", "nmi bit cleared after take", 32'(pend_o), 0);
    chk("R8", "no take after clear", 32'(take_o), 0);
    sw_set(8'h40);
    chk("R2", "set ignored on nmi line", 32'(pend_o), 0);
    irq_in = 8'h00; tick();
  endtask

  task automatic t_wfi();
    set_en(8'hFF);
    do_wfi(3'd2);
    chk("R10", "wfi loads level", 32'(cur_level_o), 2);
    chk("R10", "halted with nothing pending", 32'(halted_o), 1);
    sw_set(8'h01);
    chk("R10", "level 1 does not wake at level 2", 32'(halted_o), 1);
    chk("R6", "level 1 not taken at level 2", 32'(take_o), 0);
    sw_set(8'h02);
    chk("R10", "level 3 taken", 32'(take_o), 1);
    chk("R10", "halted falls one clock later", 32'(halted_o), 1);
    tick();
    chk("R10", "halted released", 32'(halted_o), 0);
    do_wfi(3'd0);
    chk("R10", "wfi with acceptable pending does not halt", 32'(halted_o), 0);
    chk("R10", "wfi level 0 loaded", 32'(cur_level_o), 0);
    wfi_req = 1'b1; wfi_level = 3'd5; cur_level_wr = 1'b1; cur_level_data = 3'd1;
    tick();
    wfi_req = 1'b0; cur_level_wr = 1'b0;
    chk("R11", "wfi wins over level write", 32'(cur_level_o), 5);
    chk("R10", "halted at level 5 with level 3 pending", 32'(halted_o), 1);
    sw_clr(8'h03);
    set_cur(3'd0);
    chk("R10", "still halted with nothing pending", 32'(halted_o), 1);
    irq_in = 8'h10; tick();
    chk("R10", "level line wakes: take", 32'(take_o), 1);
    tick();
    chk("R10", "halted released by level line", 32'(halted_o), 0);
    irq_in = 8'h00; tick();
  endtask

  initial begin
    repeat (3) tick();
    t_reset();
    rst_n = 1'b1;
    tick();
    t_sw_masks();
    t_collision();
    t_priority();
    t_accept();
    t_nmi();
    t_wfi();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule